// File: doc/BRIEF.md
# Load-Queue Ordering Violation Detector

This block keeps the bookkeeping of an out-of-order core's load queue and decides, each time a memory instruction executes, whether a younger load has already run ahead of it to the same memory region. Loads are allocated at the tail of a circular queue, write back their effective address (with a flag that marks the access uncacheable) once it resolves, and leave from the head when they retire.

When the execute port presents a check, it gives the executing instruction's address, its queue position and whether it is a store or a load. The block looks at every live entry younger than that position. An entry can be flagged only if it has a resolved address, is not uncacheable, and lies in the same 256-byte block as the checked address. Uncacheable loads are skipped because they only execute once they reach the head of the reorder buffer, so they cannot have run ahead. The nearest younger match, which is the oldest offender, is reported one cycle later so that the pipeline can squash and refetch from it.

Top module: `lq_order_check`

## Requirements
- R1: After reset the queue is empty, `lq_full` is 0, `alloc_idx` is 0 and `viol_valid` is 0.
- R2: `alloc_en` claims the slot shown on `alloc_idx` (the tail), and the tail then advances with wrap-around. The request is ignored while `lq_full` is 1. `retire_en` frees the head slot and is ignored while the queue is empty. A queue of DEPTH live entries raises `lq_full`.
- R3: Two addresses match when bits [ADDR_W-1:8] are equal. Bits [7:0] play no part in the comparison.
- R4: An entry whose address has not been written back through `wb_en` never matches.
- R5: An entry written back with `wb_uncache` = 1 never matches.
- R6: A store check (`chk_store` = 1) covers the live entries from `chk_idx` inclusive up to the youngest entry.
- R7: A load check (`chk_store` = 0) covers the live entries strictly younger than `chk_idx`. The checking load's own entry is excluded.
- R8: When several entries match, the one nearest to `chk_idx` in age order is reported. Age is counted from the head, so this also holds when the queue wraps past index DEPTH-1.
- R9: A check with a match raises `viol_valid` for exactly the one cycle after `chk_en`, with the slot number on `viol_idx`. A check with no match raises no pulse.
- R10: `flush` empties the queue, returns head and tail to 0, and cancels any check made in the same cycle.
- R11: A slot that is freed and then allocated again starts without a resolved address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the queue and cancel a same-cycle check |
| alloc_en | input | 1 | Allocate one load at the tail |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| lq_full | output | 1 | All DEPTH slots are live |
| retire_en | input | 1 | Free the head slot |
| wb_en | input | 1 | Write back a resolved load address |
| wb_idx | input | IDX_W | Slot receiving the address |
| wb_addr | input | ADDR_W | Effective address |
| wb_uncache | input | 1 | Load is uncacheable |
| chk_en | input | 1 | Execute-port check request |
| chk_store | input | 1 | 1: store check, 0: load check |
| chk_idx | input | IDX_W | Queue position of the checking instruction |
| chk_addr | input | ADDR_W | Address of the checking instruction |
| viol_valid | output | 1 | Violation found by the previous cycle's check |
| viol_idx | output | IDX_W | Slot of the oldest violating load |

## Verification
`alloc_idx` and `lq_full` are combinational views of the pointers. They are sampled on the falling edge before the allocation or retirement takes effect, and again on the next falling edge. A check result is due exactly one rising edge after the request, so the driver tags each expected outcome with the cycle count plus one, and the monitor compares it on the falling edge of that cycle. Any `viol_valid` that appears on a cycle where no result is due counts as a failure, which also covers the no-match and flush-cancel cases.

// File: rtl/lq_order_check.sv
module lq_order_check #(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1,
  localparam int TAG_W = ADDR_W - BLK_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_en,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             lq_full,
  input  logic             retire_en,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic             wb_uncache,
  input  logic             chk_en,
  input  logic             chk_store,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic             viol_valid,
  output logic [IDX_W-1:0] viol_idx
);

  logic [DEPTH-1:0] live_q, avld_q, unc_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign lq_full   = (cnt_q == CNT_W'(DEPTH));
  assign alloc_idx = tail_q;

  wire do_alloc = alloc_en && !lq_full;
  wire do_ret   = retire_en && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      live_q <= '0;
      avld_q <= '0;
      unc_q  <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      live_q <= '0;
      avld_q <= '0;
      unc_q  <= '0;
    end else begin
      if (wb_en && live_q[wb_idx]) begin
        avld_q[wb_idx] <= 1'b1;
        unc_q[wb_idx]  <= wb_uncache;
      end
      if (do_alloc) begin
        live_q[tail_q] <= 1'b1;
        avld_q[tail_q] <= 1'b0;
        unc_q[tail_q]  <= 1'b0;
        tail_q         <= bump(tail_q);
      end
      if (do_ret) begin
        live_q[head_q] <= 1'b0;
        avld_q[head_q] <= 1'b0;
        unc_q[head_q]  <= 1'b0;
        head_q         <= bump(head_q);
      end
      cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(do_ret);
    end
  end

  always_ff @(posedge clk) begin
    if (wb_en && live_q[wb_idx])
      tag_q[wb_idx] <= wb_addr[ADDR_W-1:BLK_SHIFT];
  end

  logic [CNT_W-1:0] chk_off, start_off;
  assign chk_off = ({1'b0, chk_idx} >= {1'b0, head_q})
                 ? {1'b0, chk_idx} - {1'b0, head_q}
                 : {1'b0, chk_idx} + CNT_W'(DEPTH) - {1'b0, head_q};
  assign start_off = chk_off + {{(CNT_W-1){1'b0}}, !chk_store};

  wire [TAG_W-1:0] chk_tag = chk_addr[ADDR_W-1:BLK_SHIFT];

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [CNT_W-1:0] sum;
      logic [IDX_W-1:0] e;
      sum = {1'b0, head_q} + CNT_W'(k);
      e   = (sum >= CNT_W'(DEPTH)) ? IDX_W'(sum - CNT_W'(DEPTH)) : IDX_W'(sum);
      if (CNT_W'(k) >= start_off && live_q[e] && avld_q[e] && !unc_q[e]
          && tag_q[e] == chk_tag) begin
        hit     = 1'b1;
        hit_idx = e;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_idx   <= '0;
    end else begin
      viol_valid <= chk_en && hit && !flush;
      viol_idx   <= hit_idx;
    end
  end

  AST_VIOL_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(chk_en) && !$past(flush)); // R9
  AST_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !chk_en) |=> !viol_valid); // R9
  AST_VIOL_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ((($past(avld_q & ~unc_q) >> viol_idx) & DEPTH'(1)) != '0)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && !viol_valid && !lq_full); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && alloc_en && !retire_en && !flush) |=> $stable(tail_q) && lq_full); // R2
  AST_RETIRE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_en && cnt_q != '0 && !flush) |=> head_q != $past(head_q)); // R2

endmodule

// File: tb/lq_order_check_bench.sv
module lq_order_check_bench;
  localparam int D = 16;

  logic clk = 0, rst_n = 0, flush = 0, alloc_en = 0, retire_en = 0;
  logic wb_en = 0, wb_uncache = 0, chk_en = 0, chk_store = 0;
  logic [3:0] wb_idx = 0, chk_idx = 0, alloc_idx, viol_idx;
  logic [31:0] wb_addr = 0, chk_addr = 0;
  logic lq_full, viol_valid;

  lq_order_check u_lq_order_check (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(alloc_en), .alloc_idx(alloc_idx), .lq_full(lq_full),
    .retire_en(retire_en),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_addr(wb_addr), .wb_uncache(wb_uncache),
    .chk_en(chk_en), .chk_store(chk_store), .chk_idx(chk_idx), .chk_addr(chk_addr),
    .viol_valid(viol_valid), .viol_idx(viol_idx));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit v; int idx; int due; string req; } exp_t;
  exp_t q[$];

  bit m_live[D], m_avld[D], m_unc[D];
  int m_tag[D];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic chk_val(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (viol_valid !== e.v || (e.v && int'(viol_idx) != e.idx)) begin
        errors++;
        $display("FAIL %s: got valid=%0d idx=%0d expected valid=%0d idx=%0d",
                 e.req, viol_valid, viol_idx, e.v, e.idx);
      end
    end else if (rst_n && viol_valid) begin
      checks++;
      errors++;
      $display("FAIL R9: got unexpected pulse idx=%0d expected no pulse", viol_idx);
    end
  end

  function automatic void predict(int idx, bit st, logic [31:0] a, output bit v, output int vi);
    int start;
    start = ((idx - m_head + D) % D) + (st ? 0 : 1);
    v = 0; vi = 0;
    for (int k = 0; k < D; k++) begin
      int e;
      e = (m_head + k) % D;
      if (!v && k >= start && m_live[e] && m_avld[e] && !m_unc[e] && m_tag[e] == int'(a >> 8)) begin
        v = 1; vi = e;
      end
    end
  endfunction

  task automatic alloc(string req);
    if (m_cnt < D) begin
      chk_val(req, alloc_idx, m_tail);
      m_live[m_tail] = 1; m_avld[m_tail] = 0; m_unc[m_tail] = 0;
      m_tail = (m_tail + 1) % D; m_cnt++;
    end
    alloc_en = 1;
    @(negedge clk);
    alloc_en = 0;
  endtask

  task automatic retire();
    if (m_cnt > 0) begin
      m_live[m_head] = 0; m_avld[m_head] = 0; m_unc[m_head] = 0;
      m_head = (m_head + 1) % D; m_cnt--;
    end
    retire_en = 1;
    @(negedge clk);
    retire_en = 0;
  endtask

  task automatic wb(int idx, logic [31:0] a, bit unc);
    if (m_live[idx]) begin
      m_avld[idx] = 1; m_unc[idx] = unc; m_tag[idx] = int'(a >> 8);
    end
    wb_en = 1; wb_idx = 4'(idx); wb_addr = a; wb_uncache = unc;
    @(negedge clk);
    wb_en = 0; wb_uncache = 0;
  endtask

  task automatic do_chk(int idx, bit st, logic [31:0] a, string req, bit with_flush = 0);
    exp_t e;
    bit v; int vi;
    predict(idx, st, a, v, vi);
    if (with_flush) v = 0;
    e.v = v; e.idx = vi; e.due = cyc + 1; e.req = req;
    q.push_back(e);
    chk_en = 1; chk_store = st; chk_idx = 4'(idx); chk_addr = a; flush = with_flush;
    if (with_flush) begin
      for (int i = 0; i < D; i++) begin m_live[i] = 0; m_avld[i] = 0; m_unc[i] = 0; end
      m_head = 0; m_tail = 0; m_cnt = 0;
    end
    @(negedge clk);
    chk_en = 0; flush = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] A = 32'h0000_3340;

  initial begin
    repeat (3) @(negedge clk);
    chk_val("R1 viol_valid", viol_valid, 0);
    chk_val("R1 lq_full", lq_full, 0);
    chk_val("R1 alloc_idx", alloc_idx, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) alloc("R2 alloc index");
    wb(1, 32'h1000_0010, 0);
    wb(2, 32'h1000_00F0, 0);
    wb(3, 32'h0000_2000, 0);
    wb(4, 32'h1000_0080, 1);
    do_chk(1, 1, 32'h1000_00FF, "R6 store includes own slot");
    do_chk(1, 0, 32'h1000_0000, "R7 load excludes own slot");
    do_chk(2, 0, 32'h1000_0000, "R5 R4 uncacheable and unresolved skipped");
    do_chk(3, 1, 32'h1000_0100, "R3 next block no match");
    wb(5, 32'h1000_00AA, 0);
    do_chk(2, 0, 32'h1000_0001, "R5 skip uncacheable to later match");
    do_chk(0, 1, 32'h1000_0000, "R8 nearest of several matches");

    for (int i = 0; i < 6; i++) retire();
    for (int i = 0; i < 14; i++) alloc("R2 alloc index wrap");
    wb(6, A, 0); wb(7, A, 0); wb(15, A, 0); wb(1, A, 0);
    do_chk(8, 1, 32'h0000_33FC, "R8 wrap-aware oldest violator");
    do_chk(15, 0, A, "R8 R7 match past the wrap");

    alloc("R2 alloc index"); alloc("R2 alloc index");
    chk_val("R2 full", lq_full, 1);
    alloc("R2 ignored when full");
    chk_val("R2 still full", lq_full, 1);
    retire();
    chk_val("R2 not full after retire", lq_full, 0);
    alloc("R11 freed slot reused");
    chk_val("R2 full again", lq_full, 1);
    do_chk(6, 1, A, "R11 reallocated slot has no address");

    do_chk(8, 1, A, "R10 flush cancels same-cycle check", 1);
    chk_val("R10 lq_full after flush", lq_full, 0);
    chk_val("R10 alloc_idx after flush", alloc_idx, 0);
    alloc("R10 alloc after flush"); alloc("R10 alloc after flush");
    do_chk(0, 1, A, "R10 flushed entries cleared");
    retire(); retire();
    retire();
    chk_val("R2 retire ignored when empty", alloc_idx, 2);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule